// File: doc/BRIEF.md
# Atomic Lock and Semaphore Unit

This block sits on the memory side of a small shared word store and serves several requesters. Each requester has a valid/ready request port carrying an operation code, a word address and a write operand. A round-robin arbiter picks at most one request per cycle. The whole read-modify-write of that request is done within that cycle: the word is read, the new value is computed and written at the clock edge. Because of this, no other requester can ever see or change the word part way through an update.

Every operation returns the word's value from before the operation. That one rule supports two uses. Software can build spin locks from test-and-set: a requester that gets 0 back now owns the lock, and a store of 0 frees it. It can also build counting semaphores: the word is set to the number of holders allowed at once, acquire takes one unit, and release gives one back. An acquire that finds the count at zero reports a failure and leaves the word untouched, so the requester can try again later.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset every memory word reads 0, and no response or ready is asserted while reset is held.
- R2: Opcode 0 (load) returns the addressed word and does not change it.
- R3: Opcode 1 (store) writes the operand to the word and returns the previous value.
- R4: Opcode 2 (test-and-set) returns the previous value and leaves the word at 1, whether it was 0 or 1 before.
- R5: Opcode 3 (fetch-and-add) adds the operand, read as signed two's complement and wrapping modulo 2^DW, and returns the previous value.
- R6: Opcode 4 (semaphore acquire) decrements a nonzero word and returns its old value with fail low. On a zero word it returns 0 with fail high and leaves the word at 0.
- R7: Opcode 5 (semaphore release) increments the word and returns the previous value.
- R8: At most one ready bit is high in any cycle, and only for a requester whose valid is high.
- R9: While several requesters are waiting, grants rotate: after requester i is granted, the next grant goes to the first valid requester after i in increasing index order, wrapping around.
- R10: A response (rsp_valid bit, data, fail flag) appears for a requester exactly one cycle after its handshake cycle and at no other time.
- R11: When every requester issues test-and-set to the same free lock at once, exactly one of them receives 0.
- R12: Opcodes 6 and 7 behave as load: they return the word and leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NREQ | Request pending, one bit per requester |
| req_ready | output | NREQ | Grant; a handshake happens when it and valid are both high |
| req_op | input | 3*NREQ | Opcode per requester |
| req_addr | input | AW*NREQ | Word address per requester |
| req_wdata | input | DW*NREQ | Store value or signed increment per requester |
| rsp_valid | output | NREQ | Response strobe per requester |
| rsp_data | output | DW*NREQ | Value of the word before the operation |
| rsp_fail | output | NREQ | Semaphore acquire found zero |

## Verification
The hardest case to reach from the ports is a true race: several requesters trying to take one free lock in the same cycle. The test raises valid on every requester at the same falling edge. It then follows the grants one cycle at a time and drops each requester's valid once it has been served. For every response it checks that the grant order rotates, that the response comes one cycle after the grant, and that only one requester gets the lock. The zero-count acquire is reached by draining a semaphore with back-to-back acquires, then reading the word back.

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit #(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREQ-1:0]      req_valid,
  output logic [NREQ-1:0]      req_ready,
  input  logic [3*NREQ-1:0]    req_op,
  input  logic [AW*NREQ-1:0]   req_addr,
  input  logic [DW*NREQ-1:0]   req_wdata,
  output logic [NREQ-1:0]      rsp_valid,
  output logic [DW*NREQ-1:0]   rsp_data,
  output logic [NREQ-1:0]      rsp_fail
);
  localparam int DEPTH = 1 << AW;
  localparam int IW    = (NREQ > 1) ? $clog2(NREQ) : 1;

  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_TAS   = 3'd2;
  localparam logic [2:0] OP_FADD  = 3'd3;
  localparam logic [2:0] OP_ACQ   = 3'd4;
  localparam logic [2:0] OP_REL   = 3'd5;

  logic [DEPTH-1:0][DW-1:0] mem;
  logic [IW-1:0]            last, gidx;
  logic                     gv, we, fail;
  logic [2:0]               g_op;
  logic [AW-1:0]            g_addr;
  logic [DW-1:0]            g_wd, cur, nxt;

  always_comb begin
    gv   = 1'b0;
    gidx = last;
    for (int k = 1; k <= NREQ; k++) begin
      int j;
      j = (int'(last) + k) % NREQ;
      if (!gv && req_valid[j]) begin
        gv   = 1'b1;
        gidx = IW'(j);
      end
    end
  end

  assign g_op   = req_op[int'(gidx)*3 +: 3];
  assign g_addr = req_addr[int'(gidx)*AW +: AW];
  assign g_wd   = req_wdata[int'(gidx)*DW +: DW];
  assign cur    = mem[g_addr];

  always_comb begin
    nxt  = cur;
    we   = 1'b0;
    fail = 1'b0;
    case (g_op)
      OP_STORE: begin nxt = g_wd;          we = 1'b1; end
      OP_TAS:   begin nxt = DW'(1);        we = 1'b1; end
      OP_FADD:  begin nxt = cur + g_wd;    we = 1'b1; end
      OP_REL:   begin nxt = cur + DW'(1);  we = 1'b1; end
      OP_ACQ:
        if (cur == '0) fail = 1'b1;
        else begin nxt = cur - DW'(1); we = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    req_ready = '0;
    if (rst_n && gv) req_ready[gidx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem       <= '0;
      last      <= IW'(NREQ - 1);
      rsp_valid <= '0;
      rsp_data  <= '0;
      rsp_fail  <= '0;
    end else begin
      rsp_valid <= req_ready;
      rsp_fail  <= '0;
      if (gv) begin
        last                          <= gidx;
        rsp_data[int'(gidx)*DW +: DW] <= cur;
        rsp_fail[gidx]                <= fail;
        if (we) mem[g_addr] <= nxt;
      end
    end
  end
endmodule

// File: rtl/atomic_mem_unit_chk.sv
module atomic_mem_unit_chk #(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NREQ-1:0]               req_valid,
  input logic [NREQ-1:0]               req_ready,
  input logic [NREQ-1:0]               rsp_valid,
  input logic                          gv,
  input logic [2:0]                    g_op,
  input logic [AW-1:0]                 g_addr,
  input logic [DW-1:0]                 cur,
  input logic [(1<<AW)-1:0][DW-1:0]    mem
);
  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready) && ((req_ready & ~req_valid) == '0));

  // R10
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rsp_valid == $past(req_ready));

  // R4
  tas_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gv && g_op == 3'd2) |=> mem[$past(g_addr)] == DW'(1));

  // R6
  acq_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gv && g_op == 3'd4 && cur == '0) |=> mem[$past(g_addr)] == '0);

  // R2
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gv && g_op == 3'd0) |=> mem[$past(g_addr)] == $past(cur));
endmodule

bind atomic_mem_unit atomic_mem_unit_chk #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .gv(gv), .g_op(g_op), .g_addr(g_addr),
  .cur(cur), .mem(mem)
);

// File: tb/tb_atomic_mem_unit.sv
module tb_atomic_mem_unit;
  localparam int N = 4, AW = 4, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0, req_ready, rsp_valid, rsp_fail;
  logic [3*N-1:0]  req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [DW*N-1:0] req_wdata = '0, rsp_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  atomic_mem_unit #(.NREQ(N), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fail(rsp_fail));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_req(input int i, input logic [2:0] op, input int a, input int wd);
    req_op[i*3 +: 3]     = op;
    req_addr[i*AW +: AW] = AW'(a);
    req_wdata[i*DW +: DW] = DW'(wd);
    req_valid[i]         = 1'b1;
  endtask

  task automatic issue(input int i, input logic [2:0] op, input int a, input int wd,
                       output int d, output bit f);
    @(negedge clk);
    set_req(i, op, a, wd);
    #1;
    while (!req_ready[i]) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid[i] = 1'b0;
    chk(rsp_valid == (N'(1) << i), "R10", int'(rsp_valid), 1 << i);
    d = int'(rsp_data[i*DW +: DW]);
    f = rsp_fail[i];
  endtask

  task automatic t_reset();
    int d; bit f;
    chk(rsp_valid == '0 && req_ready == '0, "R1", int'(rsp_valid), 0);
    issue(1, 3'd0, 3, 0, d, f);
    chk(d == 0, "R1", d, 0);
  endtask

  task automatic t_load_store();
    int d; bit f;
    issue(0, 3'd1, 2, 5, d, f);  chk(d == 0, "R3", d, 0);
    issue(2, 3'd0, 2, 0, d, f);  chk(d == 5, "R2", d, 5);
    issue(3, 3'd0, 2, 0, d, f);  chk(d == 5, "R2", d, 5);
  endtask

  task automatic t_tas();
    int d; bit f;
    issue(0, 3'd2, 4, 0, d, f);  chk(d == 0, "R4", d, 0);
    issue(1, 3'd2, 4, 0, d, f);  chk(d == 1, "R4", d, 1);
    issue(1, 3'd0, 4, 0, d, f);  chk(d == 1, "R4", d, 1);
    issue(0, 3'd1, 4, 0, d, f);  chk(d == 1, "R3", d, 1);
    issue(1, 3'd2, 4, 0, d, f);  chk(d == 0, "R4", d, 0);
  endtask

  task automatic t_fadd();
    int d; bit f;
    issue(2, 3'd1, 5, 10, d, f);
    issue(2, 3'd3, 5, 7, d, f);       chk(d == 10, "R5", d, 10);
    issue(3, 3'd3, 5, 'hFFFD, d, f);  chk(d == 17, "R5", d, 17);
    issue(3, 3'd0, 5, 0, d, f);       chk(d == 14, "R5", d, 14);
    issue(0, 3'd1, 5, 'hFFFF, d, f);
    issue(0, 3'd3, 5, 1, d, f);       chk(d == 'hFFFF, "R5", d, 'hFFFF);
    issue(0, 3'd0, 5, 0, d, f);       chk(d == 0, "R5", d, 0);
  endtask

  task automatic t_sem();
    int d; bit f;
    issue(1, 3'd1, 6, 2, d, f);
    issue(1, 3'd4, 6, 0, d, f);  chk(d == 2 && !f, "R6", d, 2);
    issue(2, 3'd4, 6, 0, d, f);  chk(d == 1 && !f, "R6", d, 1);
    issue(3, 3'd4, 6, 0, d, f);  chk(d == 0 && f,  "R6", int'(f), 1);
    issue(3, 3'd0, 6, 0, d, f);  chk(d == 0, "R6", d, 0);
    issue(0, 3'd5, 6, 0, d, f);  chk(d == 0 && !f, "R7", d, 0);
    issue(0, 3'd0, 6, 0, d, f);  chk(d == 1, "R7", d, 1);
  endtask

  task automatic t_reserved();
    int d; bit f;
    issue(2, 3'd1, 7, 9, d, f);
    issue(2, 3'd6, 7, 3, d, f);  chk(d == 9, "R12", d, 9);
    issue(1, 3'd7, 7, 3, d, f);  chk(d == 9, "R12", d, 9);
    issue(1, 3'd0, 7, 0, d, f);  chk(d == 9, "R12", d, 9);
  endtask

  task automatic t_race();
    int winners = 0, prev = -1, g;
    @(negedge clk);
    for (int i = 0; i < N; i++) set_req(i, 3'd2, 8, 0);
    #1;
    for (int c = 0; c < N; c++) begin
      chk($countones(req_ready) == 1, "R8", int'(req_ready), 1);
      g = 0;
      for (int i = 0; i < N; i++) if (req_ready[i]) g = i;
      if (prev >= 0) chk(g == (prev + 1) % N, "R9", g, (prev + 1) % N);
      prev = g;
      @(negedge clk);
      req_valid[g] = 1'b0;
      chk(rsp_valid == (N'(1) << g), "R10", int'(rsp_valid), 1 << g);
      if (rsp_data[g*DW +: DW] == '0) winners++;
      #1;
    end
    chk(winners == 1, "R11", winners, 1);
    chk(req_ready == '0, "R8", int'(req_ready), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_store();
    t_tas();
    t_fadd();
    t_sem();
    t_reserved();
    t_race();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual %0h expected %0h", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule